// File: doc/BRIEF.md
# Computer-operating-properly watchdog

This block guards a small 8-bit microcontroller against runaway software. It counts prescaled clock ticks, and if software does not service it within a fixed period it raises a reset pulse that stays inside the chip. Software services it by writing a zero in data bit 0 to one fixed clear address. An enable input, held by an option register outside the block, turns the whole function on or off. While it is disabled, the count stays at zero.

The block also owns the operating-mode latch. The latch takes the mode pins just after power-on and on every external-pin reset. A watchdog reset does not reload it, so the processor comes back in the mode it was running in. A sticky cause flag records that a watchdog reset happened. Only power-on reset clears the flag.

The control is a three-state machine:
- `COP_IDLE`: disabled.
- `COP_COUNT`: enabled and counting.
- `COP_PULSE`: the reset pulse is being driven.

Its transitions are:
- **enable**: IDLE to COUNT, when the enable goes high.
- **disable**: COUNT to IDLE, when the enable goes low.
- **expire**: IDLE or COUNT to PULSE, on the final tick.
- **pulse-done**: PULSE to COUNT or IDLE, after the pulse length, depending on the enable.
- **pin-reset**: any state to COUNT or IDLE, when the external reset is asserted.

Top module: `cop_watchdog`

## Requirements
- R1: With the enable high, a tick on every cycle and no clear, the reset output rises on the 2^CNT_W-th tick counted from a cleared counter.
- R2: A write with `wr_en` high, `wr_addr` equal to CLR_ADDR (default 0x3FF0) and `wr_lsb` low zeroes the count, and it takes priority over a tick in the same cycle.
- R3: A write to CLR_ADDR with `wr_lsb` high, or a write to any other address, leaves the count unchanged.
- R4: The count advances only on cycles where `tick` is high, so ticks on alternate cycles double the time to timeout.
- R5: With the enable low, the count is held at zero and the reset output never rises.
- R6: The reset output stays high for exactly PULSE_LEN cycles (default 4). The count is held at zero during the pulse and on the cycle that ends it, and then counting resumes.
- R7: `wd_flag` is set on the cycle the pulse starts, stays set through later events, and is cleared only by `por_n`.
- R8: `op_mode` takes `mode_pins` on the first clock after power-on and on every clock where `ext_rst` is high. A watchdog pulse never changes it.
- R9: `ext_rst` zeroes the count and ends any pulse in progress, so the reset output is low on the next cycle. It leaves `wd_flag` unchanged.
- R10: While `por_n` is low, `wd_rst` is low, `wd_flag` is low and `op_mode` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous reset from the external reset pin, active high |
| cop_en | input | 1 | Watchdog enable from the option register |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_lsb | input | 1 | Bit 0 of the bus write data |
| mode_pins | input | MODE_W | Operating-mode selection pins |
| wd_rst | output | 1 | Internal watchdog reset pulse |
| wd_flag | output | 1 | Sticky cause flag for a watchdog reset |
| op_mode | output | MODE_W | Latched operating mode |

## Verification
On every cycle the assertions check the following:
- the cause flag is sticky and is set when a pulse starts;
- a pulse never runs longer than PULSE_LEN and ends early only through the pin reset;
- no pulse can start while disabled, without a tick, or right after a valid clear;
- the mode latch holds through a watchdog pulse.

The exact timeout tick count, the effect of clears placed at particular ticks, the period with alternate-cycle ticks, and the rejection of near-miss writes are visible only in the bench's scenarios. There a behavioural reference model is compared with all outputs on every clock.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [1:0] {
        COP_IDLE  = 2'd0,
        COP_COUNT = 2'd1,
        COP_PULSE = 2'd2
    } cop_state_e;
endpackage

// File: rtl/cop_clear_decode.sv
// Recognises the service write: strobe, exact address, data bit 0 low.
module cop_clear_decode #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] CLR_ADDR = 16'h3FF0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    output logic              clr_hit
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(CLR_ADDR);

    always_comb begin
        clr_hit = wr_en && (wr_addr == MATCH) && !wr_lsb;
    end
endmodule

// File: rtl/cop_timeout_counter.sv
// Tick counter; expire marks the tick that would wrap the count.
module cop_timeout_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold_zero,
    input  logic clear,
    input  logic tick,
    output logic expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        expire = !hold_zero && !clear && tick && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (hold_zero || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cop_pulse_fsm.sv
// Control FSM: idle / counting / pulse, plus pulse timer and cause flag.
module cop_pulse_fsm
    import cop_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst,
    input  logic       enable,
    input  logic       expire,
    output cop_state_e state,
    output logic       rst_out,
    output logic       flag
);
    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PULSE_LEN - 1);

    cop_state_e state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          pulse_done;
    logic          flag_q;

    always_comb begin
        pulse_done = (pcnt_q == PLAST);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ext_rst) begin
            state_d = enable ? COP_COUNT : COP_IDLE;   // pin-reset
        end else begin
            unique case (state_q)
                COP_IDLE: begin
                    if (expire)      state_d = COP_PULSE;  // expire
                    else if (enable) state_d = COP_COUNT;  // enable
                end
                COP_COUNT: begin
                    if (expire)       state_d = COP_PULSE; // expire
                    else if (!enable) state_d = COP_IDLE;  // disable
                end
                COP_PULSE: begin
                    if (pulse_done) state_d = enable ? COP_COUNT : COP_IDLE; // pulse-done
                end
                default: state_d = COP_IDLE;
            endcase
        end
    end

    // state register, pulse timer, cause flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= COP_IDLE;
            pcnt_q  <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == COP_PULSE && state_d == COP_PULSE) pcnt_q <= pcnt_q + 1'b1;
            else                                               pcnt_q <= '0;
            if (state_d == COP_PULSE && state_q != COP_PULSE) flag_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        rst_out = (state_q == COP_PULSE);
        flag    = flag_q;
    end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CLR_ADDR  = 16'h3FF0,
    parameter int          CNT_W     = 16,
    parameter int          PULSE_LEN = 4,
    parameter int          MODE_W    = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst,
    input  logic              cop_en,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [MODE_W-1:0] mode_pins,
    output logic              wd_rst,
    output logic              wd_flag,
    output logic [MODE_W-1:0] op_mode
);
    cop_state_e        state;
    logic              clr_hit;
    logic              expire;
    logic              hold_zero;
    logic              boot_q;
    logic [MODE_W-1:0] mode_q;

    always_comb begin
        hold_zero = ext_rst || !cop_en || (state == COP_PULSE);
    end

    cop_clear_decode #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_lsb  (wr_lsb),
        .clr_hit (clr_hit)
    );

    cop_timeout_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .por_n     (por_n),
        .hold_zero (hold_zero),
        .clear     (clr_hit),
        .tick      (tick),
        .expire    (expire)
    );

    cop_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .ext_rst (ext_rst),
        .enable  (cop_en),
        .expire  (expire),
        .state   (state),
        .rst_out (wd_rst),
        .flag    (wd_flag)
    );

    // mode latch: loaded after power-on and on pin reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            boot_q <= 1'b1;
            mode_q <= '0;
        end else begin
            boot_q <= 1'b0;
            if (boot_q || ext_rst) mode_q <= mode_pins;
        end
    end

    assign op_mode = mode_q;
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CLR_ADDR  = 16'h3FF0,
    parameter int          PULSE_LEN = 4,
    parameter int          MODE_W    = 2
) (
    input logic              clk,
    input logic              por_n,
    input logic              ext_rst,
    input logic              cop_en,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_lsb,
    input logic              wd_rst,
    input logic              wd_flag,
    input logic [MODE_W-1:0] op_mode
);
    localparam int HW = $clog2(PULSE_LEN + 1) + 1;
    logic [HW-1:0] high_run;
    logic          good_clr;

    assign good_clr = wr_en && (wr_addr == ADDR_W'(CLR_ADDR)) && !wr_lsb;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      high_run <= '0;
        else if (wd_rst) high_run <= high_run + 1'b1;
        else             high_run <= '0;
    end

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        wd_flag |=> wd_flag);
    a_r7_flag_on_fire: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_rst) |-> wd_flag);
    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!por_n)
        wd_rst |-> (high_run < HW'(PULSE_LEN)));
    a_r6_pulse_full: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(wd_rst) && !$past(ext_rst)) |-> (high_run == HW'(PULSE_LEN)));
    a_r5_no_fire_disabled: assert property (@(posedge clk) disable iff (!por_n)
        (!cop_en && !wd_rst) |=> !wd_rst);
    a_r4_no_fire_without_tick: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !wd_rst) |=> !wd_rst);
    a_r2_clear_blocks_fire: assert property (@(posedge clk) disable iff (!por_n)
        (good_clr && !wd_rst) |=> !wd_rst);
    a_r8_mode_kept: assert property (@(posedge clk) disable iff (!por_n)
        (wd_rst && !ext_rst) |=> $stable(op_mode));
    a_r9_pin_ends_pulse: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst |=> !wd_rst);
endmodule

bind cop_watchdog cop_watchdog_chk #(
    .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR), .PULSE_LEN(PULSE_LEN), .MODE_W(MODE_W)
) u_chk (
    .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .cop_en(cop_en), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wd_rst(wd_rst),
    .wd_flag(wd_flag), .op_mode(op_mode)
);

// File: tb/tb_cop_watchdog.sv
`timescale 1ns/100ps
module tb_cop_watchdog;
    localparam int          ADDR_W = 16;
    localparam logic [15:0] CLR    = 16'h3FF0;
    localparam int          CW     = 6;
    localparam int          PLEN   = 4;
    localparam int          MW     = 2;
    localparam int          CMAX   = (1 << CW) - 1;

    logic clk = 0, por_n = 0, ext_rst = 0, cop_en = 0, tick = 0;
    logic wr_en = 0, wr_lsb = 0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [MW-1:0] mode_pins = 2'b10;
    logic wd_rst, wd_flag;
    logic [MW-1:0] op_mode;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cop_watchdog #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR), .CNT_W(CW),
                   .PULSE_LEN(PLEN), .MODE_W(MW)) dut (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .cop_en(cop_en), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_lsb(wr_lsb), .mode_pins(mode_pins),
        .wd_rst(wd_rst), .wd_flag(wd_flag), .op_mode(op_mode));

    // behavioural reference model
    int m_cnt, m_pulse;
    bit m_flag, m_boot;
    logic [MW-1:0] m_mode;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_cnt = 0; m_pulse = 0; m_flag = 0; m_boot = 1; m_mode = '0;
        end else begin
            if (m_boot || ext_rst) m_mode = mode_pins;
            m_boot = 0;
            if (ext_rst) begin
                m_cnt = 0; m_pulse = 0;
            end else if (m_pulse > 0) begin
                m_pulse = m_pulse - 1; m_cnt = 0;
            end else if (!cop_en) begin
                m_cnt = 0;
            end else if (wr_en && wr_addr == CLR && !wr_lsb) begin
                m_cnt = 0;
            end else if (tick) begin
                if (m_cnt == CMAX) begin
                    m_pulse = PLEN; m_flag = 1; m_cnt = 0;
                end else m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare with model every cycle
    always @(negedge clk) begin
        if (por_n && !done) begin
            chk("R6 model wd_rst", int'(wd_rst), int'(m_pulse > 0));
            chk("R7 model wd_flag", int'(wd_flag), int'(m_flag));
            chk("R8 model op_mode", int'(op_mode), int'(m_mode));
        end
    end

    // one clock: drive at negedge, sample at next negedge
    task automatic cyc(input bit t, input bit we, input logic [ADDR_W-1:0] a, input bit lsb);
        tick = t; wr_en = we; wr_addr = a; wr_lsb = lsb;
        @(posedge clk);
        @(negedge clk);
        tick = 0; wr_en = 0; wr_addr = '0; wr_lsb = 0;
    endtask

    task automatic pin_reset();
        ext_rst = 1;
        cyc(1'b0, 1'b0, '0, 1'b0);
        ext_rst = 0;
    endtask

    // edges until wd_rst is seen high; -1 if limit reached
    task automatic run_fire(input int period, input int clr_edge, input bit bad,
                            input int limit, output int k);
        k = -1;
        for (int e = 1; e <= limit; e++) begin
            bit we = 0, lsb = 0;
            logic [ADDR_W-1:0] a = '0;
            if (e == clr_edge) begin
                we = 1; a = CLR; lsb = 0;
            end else if (bad && e % 7 == 0) begin
                we = 1; a = CLR + 16'd1; lsb = 0;
            end else if (bad && e % 5 == 0) begin
                we = 1; a = CLR; lsb = 1;
            end
            cyc((e % period) == 0, we, a, lsb);
            if (wd_rst) begin k = e; break; end
        end
    endtask

    task automatic pulse_len(output int n);
        n = 1;
        while (wd_rst && n < 50) begin
            cyc(1'b1, 1'b0, '0, 1'b0);
            if (wd_rst) n++;
        end
    endtask

    initial begin
        int cyc_cnt = 0;
        while (!done) begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int k, n;
        #1;
        chk("R10 reset wd_rst", int'(wd_rst), 0);
        chk("R10 reset wd_flag", int'(wd_flag), 0);
        chk("R10 reset op_mode", int'(op_mode), 0);
        @(negedge clk); @(negedge clk);
        por_n = 1;
        repeat (3) cyc(1'b1, 1'b0, '0, 1'b0);
        chk("R8 mode after power-on", int'(op_mode), 2);

        // R1 basic timeout; R8 pin reset reloads mode
        cop_en = 1; mode_pins = 2'b01;
        pin_reset();
        chk("R8 mode after pin reset", int'(op_mode), 1);
        mode_pins = 2'b11;
        run_fire(1, 0, 0, 200, k);
        chk("R1 timeout tick count", k, CMAX + 1);
        chk("R7 flag set on fire", int'(wd_flag), 1);
        pulse_len(n);
        chk("R6 pulse length", n, PLEN);
        chk("R8 mode kept through watchdog reset", int'(op_mode), 1);
        // R6 counting resumes from zero
        run_fire(1, 0, 0, 200, k);
        chk("R6 resumed count", k, CMAX + 1);
        pulse_len(n);

        // R3 near-miss writes do not clear
        pin_reset();
        run_fire(1, 0, 1, 200, k);
        chk("R3 ignored writes", k, CMAX + 1);
        pulse_len(n);

        // R2 valid clear at edge 30 (same cycle as a tick)
        pin_reset();
        chk("R9 flag kept by pin reset", int'(wd_flag), 1);
        run_fire(1, 30, 0, 300, k);
        chk("R2 clear restarts period", k, 30 + CMAX + 1);
        pulse_len(n);

        // R4 ticks on alternate cycles
        pin_reset();
        run_fire(2, 0, 0, 400, k);
        chk("R4 alternate ticks", k, 2 * (CMAX + 1));
        pulse_len(n);

        // R5 disabled: never fires
        cop_en = 0;
        run_fire(1, 0, 0, 300, k);
        chk("R5 no fire when disabled", k, -1);

        // R9 pin reset ends pulse early
        cop_en = 1; mode_pins = 2'b00;
        pin_reset();
        run_fire(1, 0, 0, 200, k);
        cyc(1'b1, 1'b0, '0, 1'b0);
        chk("R9 pulse running", int'(wd_rst), 1);
        pin_reset();
        chk("R9 pulse ended", int'(wd_rst), 0);
        chk("R9 flag kept", int'(wd_flag), 1);
        chk("R8 mode reloaded", int'(op_mode), 0);

        // R7 only power-on clears the flag
        cop_en = 0;
        por_n = 0;
        #1;
        chk("R7 flag cleared by power-on", int'(wd_flag), 0);
        chk("R10 wd_rst in power-on", int'(wd_rst), 0);
        @(negedge clk);
        por_n = 1;
        repeat (2) cyc(1'b0, 1'b0, '0, 1'b0);
        chk("R7 flag stays clear", int'(wd_flag), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule